// File: doc/BRIEF.md
# RISC Instruction Field Decoder

This block takes one 32-bit instruction word and decodes it without any clock. It splits the word into register specifiers and an immediate. It also works out the control that an execute stage needs: an ALU operation, whether a general register is written and which field names it, memory read and write strobes, a start strobe for a separate multiply/divide unit, and a flag for words it does not recognise. The decoder covers register-register arithmetic, logic and compare operations, immediate arithmetic, logic and compare operations, multiply/divide, and word load/store. It does not handle branches, jumps, the register file, memory or exception sequencing.

The input side follows valid-only stream rules. A word qualified by `insn_valid_i` is decoded in the same cycle, and there is no ready signal. Back-pressure belongs to the stage that drives the decoder, which holds the word and its valid until the execute stage accepts the result. All strobes and the illegal flag are low while valid is low, so a stalled or empty slot never causes a side effect. The field and immediate outputs follow the word at all times.

Top module: `insn_field_decoder`

## Requirements
- R1: `rs_o`, `rt_o` and `rd_o` always equal instruction bits [25:21], [20:16] and [15:11].
- R2: For opcodes 8, 9, 10, 11, 35 and 43, and for every word outside opcodes 12 to 14, `imm_o` is bits [15:0] with bit 15 copied into bits [31:16].
- R3: For opcodes 12, 13 and 14, `imm_o` is bits [15:0] with bits [31:16] zero.
- R4: Opcode 0 with shift field zero and funct 32/33/34/35/36/37/39/40/42/43 sets `alu_op_o` to 8/0/9/1/2/3/4/5/6/7, raises `reg_we_o` and raises `dst_rd_o`. ALU codes: 0 add, 1 sub, 2 and, 3 or, 4 nor, 5 xor, 6 signed less-than, 7 unsigned less-than, 8 add trapping on overflow, 9 sub trapping on overflow.
- R5: Opcodes 8/9/10/11/12/13/14 set `alu_op_o` to 8/0/6/7/2/3/5, raise `reg_we_o` and leave `dst_rd_o` low, so the Rt field is the destination.
- R6: Opcode 35 raises `mem_rd_o` and `reg_we_o`, with `alu_op_o` 0 and `dst_rd_o` low.
- R7: Opcode 43 raises `mem_wr_o` with `alu_op_o` 0, and `reg_we_o` stays low.
- R8: Opcode 0 with funct 24, 25, 26 or 27 and zero Rd and shift fields raises `md_start_o`, sets `md_op_o` to funct[1:0] (0 signed multiply, 1 unsigned multiply, 2 signed divide, 3 unsigned divide) and writes no register.
- R9: Opcode 0 with a nonzero shift field, or a multiply/divide funct with a nonzero Rd field, is illegal.
- R10: Any opcode or funct not listed above raises `illegal_o`. All strobes, `dst_rd_o`, `alu_op_o` and `md_op_o` are then zero.
- R11: While `insn_valid_i` is low, `reg_we_o`, `dst_rd_o`, `mem_rd_o`, `mem_wr_o`, `md_start_o` and `illegal_o` are low and `alu_op_o` and `md_op_o` are zero. R1 to R3 still hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_valid_i | input | 1 | Qualifies the instruction word |
| insn_i | input | 32 | Instruction word |
| rs_o | output | 5 | First source register specifier |
| rt_o | output | 5 | Second source or immediate-form destination specifier |
| rd_o | output | 5 | Register-form destination specifier |
| imm_o | output | 32 | Extended immediate |
| alu_op_o | output | 4 | ALU operation code |
| reg_we_o | output | 1 | General register write enable |
| dst_rd_o | output | 1 | High: destination is Rd; low: destination is Rt |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| md_start_o | output | 1 | Multiply/divide start strobe |
| md_op_o | output | 2 | Multiply/divide operation |
| illegal_o | output | 1 | Unrecognised instruction |

## Verification
The embedded checks assume that `insn_valid_i` is a defined level whenever the outputs are examined, and that the driving stage holds the word stable while valid is high. The checks then require that a store never writes a register, that a multiply/divide start never writes a register, that an illegal or unqualified word raises no strobe, and that the logic immediates are never sign-extended. The stimulus changes the word and valid together once per cycle, a fixed time after the rising edge, and results are sampled only on the falling edge. It covers every listed funct and opcode, immediates with bit 15 set and clear, malformed multiply/divide and shift fields, unlisted codes, idle slots, and a pseudo-random sweep of words.

// File: rtl/ifd_pkg.sv
package ifd_pkg;

  typedef enum logic [3:0] {
    ALU_ADD      = 4'd0,
    ALU_SUB      = 4'd1,
    ALU_AND      = 4'd2,
    ALU_OR       = 4'd3,
    ALU_NOR      = 4'd4,
    ALU_XOR      = 4'd5,
    ALU_SLT      = 4'd6,
    ALU_SLTU     = 4'd7,
    ALU_ADD_TRAP = 4'd8,
    ALU_SUB_TRAP = 4'd9
  } alu_op_e;

  localparam int OPC_W = 6;
  localparam int FN_W  = 6;

  localparam logic [OPC_W-1:0] OPC_REG   = 6'd0;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'd8;
  localparam logic [OPC_W-1:0] OPC_ADDIU = 6'd9;
  localparam logic [OPC_W-1:0] OPC_SLTI  = 6'd10;
  localparam logic [OPC_W-1:0] OPC_SLTIU = 6'd11;
  localparam logic [OPC_W-1:0] OPC_ANDI  = 6'd12;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'd13;
  localparam logic [OPC_W-1:0] OPC_XORI  = 6'd14;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'd35;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'd43;

  localparam logic [FN_W-1:0] FN_MULT  = 6'd24;
  localparam logic [FN_W-1:0] FN_MULTU = 6'd25;
  localparam logic [FN_W-1:0] FN_DIV   = 6'd26;
  localparam logic [FN_W-1:0] FN_DIVU  = 6'd27;
  localparam logic [FN_W-1:0] FN_ADD   = 6'd32;
  localparam logic [FN_W-1:0] FN_ADDU  = 6'd33;
  localparam logic [FN_W-1:0] FN_SUB   = 6'd34;
  localparam logic [FN_W-1:0] FN_SUBU  = 6'd35;
  localparam logic [FN_W-1:0] FN_AND   = 6'd36;
  localparam logic [FN_W-1:0] FN_OR    = 6'd37;
  localparam logic [FN_W-1:0] FN_NOR   = 6'd39;
  localparam logic [FN_W-1:0] FN_XOR   = 6'd40;
  localparam logic [FN_W-1:0] FN_SLT   = 6'd42;
  localparam logic [FN_W-1:0] FN_SLTU  = 6'd43;

  typedef struct packed {
    logic    reg_we;
    logic    dst_rd;
    logic    mem_rd;
    logic    mem_wr;
    logic    md_start;
    logic [1:0] md_op;
    logic    illegal;
    logic    sext;
    alu_op_e alu_op;
  } ctrl_t;

endpackage

// File: rtl/ifd_imm_ext.sv
module ifd_imm_ext #(
  parameter int IMM_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              sext_i,
  output logic [DATA_W-1:0] imm_o
);
  localparam int PAD_W = DATA_W - IMM_W;

  logic fill;
  assign fill = sext_i & imm_i[IMM_W-1];

  generate
    if (PAD_W > 0) begin : g_pad
      assign imm_o = {{PAD_W{fill}}, imm_i};
    end else begin : g_nopad
      assign imm_o = imm_i[DATA_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/ifd_ctrl.sv
module ifd_ctrl
  import ifd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             valid_i,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic [FN_W-1:0]  funct_i,
  input  logic [REG_W-1:0] rd_i,
  input  logic [REG_W-1:0] shamt_i,
  output ctrl_t            ctrl_o
);
  ctrl_t raw;

  // Table decode of the opcode and funct groups.
  always_comb begin
    raw        = '0;
    raw.sext   = 1'b1;
    raw.alu_op = ALU_ADD;
    case (opcode_i)
      OPC_REG: begin
        if (shamt_i != '0) begin
          raw.illegal = 1'b1;
        end else begin
          raw.reg_we = 1'b1;
          raw.dst_rd = 1'b1;
          case (funct_i)
            FN_ADD:  raw.alu_op = ALU_ADD_TRAP;
            FN_ADDU: raw.alu_op = ALU_ADD;
            FN_SUB:  raw.alu_op = ALU_SUB_TRAP;
            FN_SUBU: raw.alu_op = ALU_SUB;
            FN_AND:  raw.alu_op = ALU_AND;
            FN_OR:   raw.alu_op = ALU_OR;
            FN_NOR:  raw.alu_op = ALU_NOR;
            FN_XOR:  raw.alu_op = ALU_XOR;
            FN_SLT:  raw.alu_op = ALU_SLT;
            FN_SLTU: raw.alu_op = ALU_SLTU;
            FN_MULT, FN_MULTU, FN_DIV, FN_DIVU: begin
              raw.reg_we = 1'b0;
              raw.dst_rd = 1'b0;
              if (rd_i != '0) begin
                raw.illegal = 1'b1;
              end else begin
                raw.md_start = 1'b1;
                raw.md_op    = funct_i[1:0];
              end
            end
            default: raw.illegal = 1'b1;
          endcase
        end
      end
      OPC_ADDI:  begin raw.reg_we = 1'b1; raw.alu_op = ALU_ADD_TRAP; end
      OPC_ADDIU: begin raw.reg_we = 1'b1; raw.alu_op = ALU_ADD;      end
      OPC_SLTI:  begin raw.reg_we = 1'b1; raw.alu_op = ALU_SLT;      end
      OPC_SLTIU: begin raw.reg_we = 1'b1; raw.alu_op = ALU_SLTU;     end
      OPC_ANDI:  begin raw.reg_we = 1'b1; raw.alu_op = ALU_AND; raw.sext = 1'b0; end
      OPC_ORI:   begin raw.reg_we = 1'b1; raw.alu_op = ALU_OR;  raw.sext = 1'b0; end
      OPC_XORI:  begin raw.reg_we = 1'b1; raw.alu_op = ALU_XOR; raw.sext = 1'b0; end
      OPC_LOAD:  begin raw.reg_we = 1'b1; raw.mem_rd = 1'b1; end
      OPC_STORE: begin raw.mem_wr = 1'b1; end
      default:   raw.illegal = 1'b1;
    endcase
  end

  // Qualification: idle slots and illegal words carry no side effect.
  always_comb begin
    ctrl_o = raw;
    if (!valid_i) begin
      ctrl_o      = '0;
      ctrl_o.sext = raw.sext;
    end else if (raw.illegal) begin
      ctrl_o         = '0;
      ctrl_o.illegal = 1'b1;
      ctrl_o.sext    = raw.sext;
    end
  end

  always_comb begin
    assert_illegal_no_strobe_R10: assert (!(ctrl_o.illegal &&
      (ctrl_o.reg_we || ctrl_o.mem_rd || ctrl_o.mem_wr || ctrl_o.md_start)));
    assert_md_needs_zero_rd_R9: assert (!(ctrl_o.md_start && rd_i != '0));
  end
endmodule

// File: rtl/insn_field_decoder.sv
module insn_field_decoder
  import ifd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  parameter int IMM_W  = 16
) (
  input  logic              insn_valid_i,
  input  logic [DATA_W-1:0] insn_i,
  output logic [REG_W-1:0]  rs_o,
  output logic [REG_W-1:0]  rt_o,
  output logic [REG_W-1:0]  rd_o,
  output logic [DATA_W-1:0] imm_o,
  output logic [3:0]        alu_op_o,
  output logic              reg_we_o,
  output logic              dst_rd_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic              md_start_o,
  output logic [1:0]        md_op_o,
  output logic              illegal_o
);
  localparam int OPC_LSB = DATA_W - OPC_W;
  localparam int RS_LSB  = OPC_LSB - REG_W;
  localparam int RT_LSB  = RS_LSB - REG_W;
  localparam int RD_LSB  = RT_LSB - REG_W;
  localparam int SH_LSB  = RD_LSB - REG_W;

  logic [OPC_W-1:0] opcode;
  logic [FN_W-1:0]  funct;
  logic [REG_W-1:0] shamt;
  ctrl_t            ctrl;

  assign opcode = insn_i[DATA_W-1:OPC_LSB];
  assign rs_o   = insn_i[OPC_LSB-1:RS_LSB];
  assign rt_o   = insn_i[RS_LSB-1:RT_LSB];
  assign rd_o   = insn_i[RT_LSB-1:RD_LSB];
  assign shamt  = insn_i[RD_LSB-1:SH_LSB];
  assign funct  = insn_i[FN_W-1:0];

  ifd_ctrl #(.REG_W(REG_W)) u_ctrl (
    .valid_i  (insn_valid_i),
    .opcode_i (opcode),
    .funct_i  (funct),
    .rd_i     (rd_o),
    .shamt_i  (shamt),
    .ctrl_o   (ctrl)
  );

  ifd_imm_ext #(.IMM_W(IMM_W), .DATA_W(DATA_W)) u_imm (
    .imm_i  (insn_i[IMM_W-1:0]),
    .sext_i (ctrl.sext),
    .imm_o  (imm_o)
  );

  assign alu_op_o   = ctrl.alu_op;
  assign reg_we_o   = ctrl.reg_we;
  assign dst_rd_o   = ctrl.dst_rd;
  assign mem_rd_o   = ctrl.mem_rd;
  assign mem_wr_o   = ctrl.mem_wr;
  assign md_start_o = ctrl.md_start;
  assign md_op_o    = ctrl.md_op;
  assign illegal_o  = ctrl.illegal;

  always_comb begin
    assert_idle_quiet_R11: assert (insn_valid_i || !(reg_we_o || dst_rd_o ||
      mem_rd_o || mem_wr_o || md_start_o || illegal_o));
    assert_store_no_we_R7: assert (!(mem_wr_o && reg_we_o));
    assert_md_no_we_R8: assert (!(md_start_o && reg_we_o));
    assert_one_side_effect_R10: assert ($onehot0({mem_rd_o, mem_wr_o, md_start_o, illegal_o}));
    assert_logic_imm_zext_R3: assert (!(opcode inside {OPC_ANDI, OPC_ORI, OPC_XORI}) ||
      imm_o[DATA_W-1:IMM_W] == '0);
    assert_rd_dest_writes_R4: assert (!dst_rd_o || reg_we_o);
  end
endmodule

// File: tb/insn_field_decoder_test.sv
module insn_field_decoder_test;
  localparam int EXP_W = 59;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic [31:0] insn = '0;

  logic [4:0]  rs, rt, rd;
  logic [31:0] imm;
  logic [3:0]  alu_op;
  logic        reg_we, dst_rd, mem_rd, mem_wr, md_start, illegal;
  logic [1:0]  md_op;

  int n_cmp = 0;
  int n_bad = 0;
  logic [EXP_W-1:0] exp_q[$];
  string            tag_q[$];

  always #5 clk = ~clk;

  insn_field_decoder uut (
    .insn_valid_i (vld), .insn_i (insn),
    .rs_o (rs), .rt_o (rt), .rd_o (rd), .imm_o (imm),
    .alu_op_o (alu_op), .reg_we_o (reg_we), .dst_rd_o (dst_rd),
    .mem_rd_o (mem_rd), .mem_wr_o (mem_wr), .md_start_o (md_start),
    .md_op_o (md_op), .illegal_o (illegal)
  );

  // Reference built from the requirement text.
  function automatic logic [EXP_W-1:0] model(logic [31:0] w, logic v);
    logic [5:0] op = w[31:26];
    logic [5:0] fn = w[5:0];
    logic [31:0] x;
    logic [3:0] a = 4'd0;
    logic we = 0, dr = 0, mr = 0, mw = 0, ms = 0, il = 0;
    logic [1:0] mo = 2'd0;
    x = (op inside {6'd12, 6'd13, 6'd14}) ? {16'h0, w[15:0]}   // R3
                                          : {{16{w[15]}}, w[15:0]}; // R2
    case (op)
      6'd0: begin
        if (w[10:6] != 0) il = 1;                           // R9
        else case (fn)
          6'd32: begin a = 8; we = 1; dr = 1; end            // R4
          6'd33: begin a = 0; we = 1; dr = 1; end
          6'd34: begin a = 9; we = 1; dr = 1; end
          6'd35: begin a = 1; we = 1; dr = 1; end
          6'd36: begin a = 2; we = 1; dr = 1; end
          6'd37: begin a = 3; we = 1; dr = 1; end
          6'd39: begin a = 4; we = 1; dr = 1; end
          6'd40: begin a = 5; we = 1; dr = 1; end
          6'd42: begin a = 6; we = 1; dr = 1; end
          6'd43: begin a = 7; we = 1; dr = 1; end
          6'd24, 6'd25, 6'd26, 6'd27:                         // R8
            if (w[15:11] != 0) il = 1;
            else begin ms = 1; mo = fn[1:0]; end
          default: il = 1;                                    // R10
        endcase
      end
      6'd8:  begin a = 8; we = 1; end                         // R5
      6'd9:  begin a = 0; we = 1; end
      6'd10: begin a = 6; we = 1; end
      6'd11: begin a = 7; we = 1; end
      6'd12: begin a = 2; we = 1; end
      6'd13: begin a = 3; we = 1; end
      6'd14: begin a = 5; we = 1; end
      6'd35: begin we = 1; mr = 1; end                        // R6
      6'd43: begin mw = 1; end                                // R7
      default: il = 1;
    endcase
    if (!v || il) begin a = 0; we = 0; dr = 0; mr = 0; mw = 0; ms = 0; mo = 0; end
    if (!v) il = 0;                                           // R11
    return {w[25:21], w[20:16], w[15:11], x, a, we, dr, mr, mw, ms, mo, il};
  endfunction

  function automatic logic [31:0] rw(logic [5:0] fn, logic [4:0] s, logic [4:0] t,
                                     logic [4:0] d, logic [4:0] sh);
    return {6'd0, s, t, d, sh, fn};
  endfunction

  function automatic logic [31:0] iw(logic [5:0] op, logic [4:0] s, logic [4:0] t,
                                     logic [15:0] im);
    return {op, s, t, im};
  endfunction

  task automatic send(logic [31:0] w, logic v, string tag);
    @(posedge clk);
    #2;
    insn = w;
    vld  = v;
    exp_q.push_back(model(w, v));
    tag_q.push_back(tag);
  endtask

  // Monitor: compare on the falling edge, away from input changes.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [EXP_W-1:0] e;
      logic [EXP_W-1:0] got;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      got = {rs, rt, rd, imm, alu_op, reg_we, dst_rd, mem_rd, mem_wr, md_start, md_op, illegal};
      n_cmp++;
      if (got !== e) begin
        n_bad++;
        $display("FAIL %s: insn=%h valid=%b actual=%h expected=%h", t, insn, vld, got, e);
      end
    end
  end

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      n_bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<50000", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    logic [5:0] fns[10] = '{6'd32, 6'd33, 6'd34, 6'd35, 6'd36, 6'd37, 6'd39, 6'd40, 6'd42, 6'd43};
    logic [5:0] iops[7] = '{6'd8, 6'd9, 6'd10, 6'd11, 6'd12, 6'd13, 6'd14};
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    send(32'h0, 1'b0, "R11 reset idle");
    send(iw(6'd35, 5'd3, 5'd4, 16'h8000), 1'b0, "R11 idle load");
    send(iw(6'd43, 5'd1, 5'd2, 16'h0004), 1'b0, "R11 idle store");
    foreach (fns[i]) send(rw(fns[i], 5'd7, 5'd9, 5'd21, 5'd0), 1'b1, "R4 reg-reg");
    foreach (iops[i]) begin
      send(iw(iops[i], 5'd17, 5'd30, 16'h8001), 1'b1, "R5 R2 R3 imm neg");
      send(iw(iops[i], 5'd2, 5'd5, 16'h7ffe), 1'b1, "R5 imm pos");
    end
    send(iw(6'd35, 5'd29, 5'd8, 16'hfffc), 1'b1, "R6 load");
    send(iw(6'd35, 5'd1, 5'd31, 16'h0010), 1'b1, "R6 load pos");
    send(iw(6'd43, 5'd29, 5'd8, 16'hfff0), 1'b1, "R7 store");
    for (int f = 24; f < 28; f++) send(rw(6'(f), 5'd11, 5'd12, 5'd0, 5'd0), 1'b1, "R8 muldiv");
    send(rw(6'd26, 5'd11, 5'd12, 5'd1, 5'd0), 1'b1, "R9 muldiv rd");
    send(rw(6'd24, 5'd11, 5'd12, 5'd0, 5'd4), 1'b1, "R9 muldiv shamt");
    send(rw(6'd32, 5'd1, 5'd2, 5'd3, 5'd1), 1'b1, "R9 alu shamt");
    send(rw(6'd0, 5'd1, 5'd2, 5'd3, 5'd0), 1'b1, "R10 funct 0");
    send(rw(6'd38, 5'd1, 5'd2, 5'd3, 5'd0), 1'b1, "R10 funct 38");
    send(rw(6'd41, 5'd1, 5'd2, 5'd3, 5'd0), 1'b1, "R10 funct 41");
    send(iw(6'd2, 5'd1, 5'd2, 16'h9000), 1'b1, "R10 opcode 2");
    send(iw(6'd15, 5'd1, 5'd2, 16'h9000), 1'b1, "R10 opcode 15");
    send(iw(6'd63, 5'd31, 5'd31, 16'hffff), 1'b1, "R10 opcode 63");
    send(iw(6'd7, 5'd1, 5'd2, 16'h0), 1'b0, "R11 idle illegal");
    lfsr = 32'h1ace_b00c;
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (k % 3 == 0) lfsr[31:26] = (k % 2 == 0) ? 6'd0 : iops[k % 7];
      send(lfsr, (k % 9) != 0, "R1 sweep");
    end
    repeat (3) @(posedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule